// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit computes, in a single combinational pass, the byte address a load or store presents to memory and the new value of its base register. A decode stage supplies the base and index register values, the raw immediate field, the program counter, and small select codes for addressing mode, offset source, shift amount and access size. The unit returns the address, the writeback value with its enable, a flag for a misaligned stack-pointer access, and a flag for an operand combination the modes do not allow.

Four addressing modes are covered. Plain offset leaves the base untouched. Pre-index accesses at the new address and writes it back. Post-index accesses at the old address and writes the new one back. Literal mode adds the offset to the program counter. In offset mode the offset can be an immediate scaled by the access size, the index register, or the index register shifted left. The two indexing modes take only a short signed immediate, and any register source is refused there.

Top module: `agu_top`

## Requirements
- R1: With mode_i=0 (offset) and src_i=0 (immediate), addr_o equals base_i plus the zero-extended imm_i shifted left by size_i, modulo 2^64.
- R2: size_i codes 0, 1, 2 and 3 scale the unsigned immediate by 1, 2, 4 and 8 bytes respectively.
- R3: With mode_i=0 and src_i=1 (register), addr_o equals base_i plus index_i.
- R4: With mode_i=0 and src_i=2 (shifted register), addr_o equals base_i plus index_i shifted left by shamt_i.
- R5: With mode_i=1 (pre-index) and an immediate source, addr_o and wb_data_o both equal base_i plus the offset, and wb_en_o is 1.
- R6: With mode_i=2 (post-index) and an immediate source, addr_o equals base_i unchanged, wb_data_o equals base_i plus the offset, and wb_en_o is 1.
- R7: In pre-index and post-index modes the offset is the low 9 bits of imm_i, sign-extended to 64 bits and not scaled; the upper immediate bits and size_i have no effect.
- R8: A register source (src_i=1 or 2) in pre-index or post-index mode, or src_i=3 in any mode except literal, sets reject_o to 1, forces wb_en_o and align_fault_o to 0, and gives addr_o equal to base_i.
- R9: When sp_base_i is 1 and the mode is not literal, align_fault_o is 1 exactly when addr_o is not a multiple of 16; it is 0 when sp_base_i is 0.
- R10: With mode_i=3 (literal), addr_o equals pc_i plus the full 12-bit imm_i sign-extended; base_i, src_i and sp_base_i have no effect, and wb_en_o and align_fault_o are 0.
- R11: wb_en_o is 1 only in pre-index or post-index mode with an accepted operand; offset and literal modes never write back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| base_i | input | 64 | Base register value |
| index_i | input | 64 | Index register value |
| imm_i | input | 12 | Raw immediate field |
| pc_i | input | 64 | Program counter of the access |
| mode_i | input | 2 | 0 offset, 1 pre-index, 2 post-index, 3 literal |
| src_i | input | 2 | 0 immediate, 1 register, 2 shifted register, 3 reserved |
| shamt_i | input | 6 | Left shift applied to the index register |
| size_i | input | 2 | Access size code, bytes = 1 << code |
| sp_base_i | input | 1 | Base register is the stack pointer |
| addr_o | output | 64 | Effective memory address |
| wb_data_o | output | 64 | New base register value |
| wb_en_o | output | 1 | Base register writeback enable |
| align_fault_o | output | 1 | Misaligned stack-pointer access |
| reject_o | output | 1 | Operand combination not allowed |

## Verification
All five results follow from the inputs with no register in between, so each one is due in the same cycle the stimulus is applied. The bench changes inputs just after a rising clock edge and reads the outputs at the next falling edge, half a period later, when the combinational paths have long settled and no clock edge is near. The checker evaluates its properties on every change of the inputs, so a wrong mix of outputs cannot hide between samples.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    MODE_OFS  = 2'd0,
    MODE_PRE  = 2'd1,
    MODE_POST = 2'd2,
    MODE_LIT  = 2'd3
  } agu_mode_e;

  typedef enum logic [1:0] {
    SRC_IMM = 2'd0,
    SRC_REG = 2'd1,
    SRC_SHR = 2'd2,
    SRC_RSV = 2'd3
  } agu_src_e;

endpackage

// File: rtl/agu_offset_gen.sv
module agu_offset_gen
  import agu_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int IMM_W  = 12,
  parameter int SIMM_W = 9,
  parameter int SH_W   = 6,
  parameter int SZ_W   = 2
) (
  input  agu_mode_e       mode_i,
  input  agu_src_e        src_i,
  input  logic [XLEN-1:0] index_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [SH_W-1:0] shamt_i,
  input  logic [SZ_W-1:0] size_i,
  output logic [XLEN-1:0] offset_o,
  output logic            reject_o
);

  localparam int UEXT_W = XLEN - IMM_W;
  localparam int SEXT_W = XLEN - SIMM_W;

  logic [XLEN-1:0] uimm_scaled;
  logic [XLEN-1:0] simm_ext;
  logic [XLEN-1:0] limm_ext;
  logic [XLEN-1:0] idx_shifted;

  always_comb begin
    uimm_scaled = {{UEXT_W{1'b0}}, imm_i} << size_i;
    simm_ext    = {{SEXT_W{imm_i[SIMM_W-1]}}, imm_i[SIMM_W-1:0]};
    limm_ext    = {{UEXT_W{imm_i[IMM_W-1]}}, imm_i};
    idx_shifted = index_i << shamt_i;
  end

  always_comb begin
    offset_o = '0;
    reject_o = 1'b0;
    unique case (mode_i)
      MODE_LIT: offset_o = limm_ext;
      MODE_PRE, MODE_POST: begin
        // indexing forms carry a short signed immediate only
        if (src_i == SRC_IMM) offset_o = simm_ext;
        else                  reject_o = 1'b1;
      end
      default: begin
        unique case (src_i)
          SRC_IMM: offset_o = uimm_scaled;
          SRC_REG: offset_o = index_i;
          SRC_SHR: offset_o = idx_shifted;
          default: reject_o = 1'b1;
        endcase
      end
    endcase
  end

endmodule

// File: rtl/agu_adder.sv
module agu_adder #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] sum_o
);

  assign sum_o = a_i + b_i;

endmodule

// File: rtl/agu_align_chk.sv
module agu_align_chk #(
  parameter int XLEN        = 64,
  parameter int ALIGN_BYTES = 16
) (
  input  logic [XLEN-1:0] addr_i,
  input  logic            check_en_i,
  output logic            fault_o
);

  localparam int LSB_W = $clog2(ALIGN_BYTES);

  generate
    if (LSB_W == 0) begin : g_no_align
      assign fault_o = 1'b0;
    end else begin : g_align
      assign fault_o = check_en_i & (|addr_i[LSB_W-1:0]);
    end
  endgenerate

endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
#(
  parameter int XLEN        = 64,
  parameter int IMM_W       = 12,
  parameter int SIMM_W      = 9,
  parameter int SH_W        = 6,
  parameter int SZ_W        = 2,
  parameter int SP_ALIGN    = 16
) (
  input  logic [XLEN-1:0]  base_i,
  input  logic [XLEN-1:0]  index_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       src_i,
  input  logic [SH_W-1:0]  shamt_i,
  input  logic [SZ_W-1:0]  size_i,
  input  logic             sp_base_i,
  output logic [XLEN-1:0]  addr_o,
  output logic [XLEN-1:0]  wb_data_o,
  output logic             wb_en_o,
  output logic             align_fault_o,
  output logic             reject_o
);

  agu_mode_e       mode;
  agu_src_e        src;
  logic [XLEN-1:0] offset;
  logic            rej;
  logic [XLEN-1:0] sum_base;
  logic [XLEN-1:0] sum;
  logic            chk_en;

  assign mode = agu_mode_e'(mode_i);
  assign src  = agu_src_e'(src_i);

  agu_offset_gen #(
    .XLEN  (XLEN),
    .IMM_W (IMM_W),
    .SIMM_W(SIMM_W),
    .SH_W  (SH_W),
    .SZ_W  (SZ_W)
  ) u_ofs (
    .mode_i  (mode),
    .src_i   (src),
    .index_i (index_i),
    .imm_i   (imm_i),
    .shamt_i (shamt_i),
    .size_i  (size_i),
    .offset_o(offset),
    .reject_o(rej)
  );

  assign sum_base = (mode == MODE_LIT) ? pc_i : base_i;

  agu_adder #(.XLEN(XLEN)) u_add (
    .a_i  (sum_base),
    .b_i  (offset),
    .sum_o(sum)
  );

  always_comb begin
    addr_o  = sum;
    wb_en_o = 1'b0;
    if (rej) begin
      addr_o = base_i;
    end else begin
      unique case (mode)
        MODE_PRE:  wb_en_o = 1'b1;
        MODE_POST: begin
          addr_o  = base_i;
          wb_en_o = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign wb_data_o = sum;
  assign reject_o  = rej;
  assign chk_en    = sp_base_i & ~rej & (mode != MODE_LIT);

  agu_align_chk #(
    .XLEN       (XLEN),
    .ALIGN_BYTES(SP_ALIGN)
  ) u_aln (
    .addr_i    (addr_o),
    .check_en_i(chk_en),
    .fault_o   (align_fault_o)
  );

endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
  parameter int XLEN = 64
) (
  input logic [XLEN-1:0] base_i,
  input logic [XLEN-1:0] pc_i,
  input logic [1:0]      mode_i,
  input logic            sp_base_i,
  input logic [XLEN-1:0] addr_o,
  input logic [XLEN-1:0] wb_data_o,
  input logic            wb_en_o,
  input logic            align_fault_o,
  input logic            reject_o
);

  always_comb begin
    AST_WB_ONLY_INDEXED: assert (!wb_en_o || mode_i == 2'd1 || mode_i == 2'd2)
      else $error("write back outside indexing mode"); // R11
    AST_PRE_ADDR_IS_WB: assert (!(wb_en_o && mode_i == 2'd1) || addr_o == wb_data_o)
      else $error("pre-index address differs from writeback"); // R5
    AST_POST_ADDR_IS_BASE: assert (!(mode_i == 2'd2 && !reject_o) || addr_o == base_i)
      else $error("post-index address moved"); // R6
    AST_REJECT_QUIET: assert (!reject_o || (!wb_en_o && !align_fault_o && addr_o == base_i))
      else $error("rejected access still acts"); // R8
    AST_FAULT_NEEDS_SP: assert (!align_fault_o || (sp_base_i && addr_o[3:0] != 4'd0))
      else $error("fault without misaligned stack access"); // R9
    AST_LIT_NO_SIDE: assert (mode_i != 2'd3 || (!wb_en_o && !align_fault_o && !reject_o))
      else $error("literal mode side effect"); // R10
  end

  logic unused_pc;
  assign unused_pc = ^pc_i;

endmodule

bind agu_top agu_checker #(.XLEN(XLEN)) u_chk (
  .base_i       (base_i),
  .pc_i         (pc_i),
  .mode_i       (mode_i),
  .sp_base_i    (sp_base_i),
  .addr_o       (addr_o),
  .wb_data_o    (wb_data_o),
  .wb_en_o      (wb_en_o),
  .align_fault_o(align_fault_o),
  .reject_o     (reject_o)
);

// File: tb/sim_agu_top.sv
module sim_agu_top;

  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  src;
    logic [1:0]  size;
    logic [5:0]  shamt;
    logic        sp;
    logic [63:0] base;
    logic [63:0] index;
    logic [11:0] imm;
    logic [63:0] pc;
    logic [63:0] e_addr;
    logic [63:0] e_wb;
    logic        e_wben;
    logic        e_fault;
    logic        e_rej;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    // R1: offset imm, doubleword scale
    '{2'd0, 2'd0, 2'd3, 6'd0, 1'b0, 64'h1000, 64'h0, 12'h003, 64'h0, 64'h1018, 64'h0, 1'b0, 1'b0, 1'b0, 8'd1},
    // R1: wrap modulo 2^64
    '{2'd0, 2'd0, 2'd3, 6'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFF8, 64'h0, 12'h002, 64'h0, 64'h8, 64'h0, 1'b0, 1'b0, 1'b0, 8'd1},
    // R2: byte, half, word scale
    '{2'd0, 2'd0, 2'd0, 6'd0, 1'b0, 64'h1000, 64'h0, 12'hFFF, 64'h0, 64'h1FFF, 64'h0, 1'b0, 1'b0, 1'b0, 8'd2},
    '{2'd0, 2'd0, 2'd1, 6'd0, 1'b0, 64'h1000, 64'h0, 12'h005, 64'h0, 64'h100A, 64'h0, 1'b0, 1'b0, 1'b0, 8'd2},
    '{2'd0, 2'd0, 2'd2, 6'd0, 1'b0, 64'h1000, 64'h0, 12'h005, 64'h0, 64'h1014, 64'h0, 1'b0, 1'b0, 1'b0, 8'd2},
    // R3: register offset, imm ignored
    '{2'd0, 2'd1, 2'd3, 6'd0, 1'b0, 64'h1000, 64'h20, 12'h7FF, 64'h0, 64'h1020, 64'h0, 1'b0, 1'b0, 1'b0, 8'd3},
    // R4: shifted register
    '{2'd0, 2'd2, 2'd0, 6'd3, 1'b0, 64'h1000, 64'h21, 12'h0, 64'h0, 64'h1108, 64'h0, 1'b0, 1'b0, 1'b0, 8'd4},
    // R5: pre-index positive
    '{2'd1, 2'd0, 2'd0, 6'd0, 1'b0, 64'h1000, 64'h0, 12'h010, 64'h0, 64'h1010, 64'h1010, 1'b1, 1'b0, 1'b0, 8'd5},
    // R7: pre-index negative, size not applied
    '{2'd1, 2'd0, 2'd3, 6'd0, 1'b0, 64'h1000, 64'h0, 12'h1F0, 64'h0, 64'h0FF0, 64'h0FF0, 1'b1, 1'b0, 1'b0, 8'd7},
    // R7: upper immediate bits ignored
    '{2'd1, 2'd0, 2'd3, 6'd0, 1'b0, 64'h1000, 64'h0, 12'hE10, 64'h0, 64'h1010, 64'h1010, 1'b1, 1'b0, 1'b0, 8'd7},
    // R6: post-index
    '{2'd2, 2'd0, 2'd0, 6'd0, 1'b0, 64'h1000, 64'h0, 12'h010, 64'h0, 64'h1000, 64'h1010, 1'b1, 1'b0, 1'b0, 8'd6},
    // R6: post-index stack pop, aligned
    '{2'd2, 2'd0, 2'd3, 6'd0, 1'b1, 64'h2000, 64'h0, 12'h010, 64'h0, 64'h2000, 64'h2010, 1'b1, 1'b0, 1'b0, 8'd6},
    // R9: pre-index stack push, aligned
    '{2'd1, 2'd0, 2'd3, 6'd0, 1'b1, 64'h2000, 64'h0, 12'h1F0, 64'h0, 64'h1FF0, 64'h1FF0, 1'b1, 1'b0, 1'b0, 8'd9},
    // R9: misaligned stack offset access
    '{2'd0, 2'd0, 2'd3, 6'd0, 1'b1, 64'h2000, 64'h0, 12'h001, 64'h0, 64'h2008, 64'h0, 1'b0, 1'b1, 1'b0, 8'd9},
    // R9: same address, not stack pointer
    '{2'd0, 2'd0, 2'd3, 6'd0, 1'b0, 64'h2000, 64'h0, 12'h001, 64'h0, 64'h2008, 64'h0, 1'b0, 1'b0, 1'b0, 8'd9},
    // R9: post-index checks the old base
    '{2'd2, 2'd0, 2'd0, 6'd0, 1'b1, 64'h2008, 64'h0, 12'h008, 64'h0, 64'h2008, 64'h2010, 1'b1, 1'b1, 1'b0, 8'd9},
    // R8: register source in pre-index
    '{2'd1, 2'd1, 2'd0, 6'd0, 1'b0, 64'h1000, 64'h40, 12'h010, 64'h0, 64'h1000, 64'h0, 1'b0, 1'b0, 1'b1, 8'd8},
    // R8: shifted register in post-index, misaligned sp but no fault
    '{2'd2, 2'd2, 2'd0, 6'd2, 1'b1, 64'h2004, 64'h40, 12'h010, 64'h0, 64'h2004, 64'h0, 1'b0, 1'b0, 1'b1, 8'd8},
    // R8: reserved source in offset mode
    '{2'd0, 2'd3, 2'd0, 6'd0, 1'b0, 64'h1000, 64'h40, 12'h010, 64'h0, 64'h1000, 64'h0, 1'b0, 1'b0, 1'b1, 8'd8},
    // R10: literal negative, base/src/sp ignored
    '{2'd3, 2'd1, 2'd3, 6'd0, 1'b1, 64'h1234, 64'h40, 12'h800, 64'h4000, 64'h3800, 64'h0, 1'b0, 1'b0, 1'b0, 8'd10},
    // R10: literal positive, unaligned result no fault
    '{2'd3, 2'd3, 2'd0, 6'd0, 1'b1, 64'h0, 64'h0, 12'h7FF, 64'h4000, 64'h47FF, 64'h0, 1'b0, 1'b0, 1'b0, 8'd10}
  };

  logic        clk;
  logic        rst_ni;
  logic [63:0] base_i, index_i, pc_i;
  logic [11:0] imm_i;
  logic [1:0]  mode_i, src_i, size_i;
  logic [5:0]  shamt_i;
  logic        sp_base_i;
  logic [63:0] addr_o, wb_data_o;
  logic        wb_en_o, align_fault_o, reject_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  agu_top u0 (
    .base_i       (base_i),
    .index_i      (index_i),
    .imm_i        (imm_i),
    .pc_i         (pc_i),
    .mode_i       (mode_i),
    .src_i        (src_i),
    .shamt_i      (shamt_i),
    .size_i       (size_i),
    .sp_base_i    (sp_base_i),
    .addr_o       (addr_o),
    .wb_data_o    (wb_data_o),
    .wb_en_o      (wb_en_o),
    .align_fault_o(align_fault_o),
    .reject_o     (reject_o)
  );

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(posedge clk);
    #1;
    mode_i = v.mode; src_i = v.src; size_i = v.size; shamt_i = v.shamt;
    sp_base_i = v.sp; base_i = v.base; index_i = v.index; imm_i = v.imm; pc_i = v.pc;
    @(negedge clk);
  endtask

  task automatic check_vec(input vec_t v);
    string tag;
    tag = $sformatf("R%0d", v.req);
    check(tag, "addr", addr_o, v.e_addr);
    check("R11", "wb_en", 64'(wb_en_o), 64'(v.e_wben));
    check(tag, "fault", 64'(align_fault_o), 64'(v.e_fault));
    check(tag, "reject", 64'(reject_o), 64'(v.e_rej));
    if (v.e_wben) check(tag, "wb_data", wb_data_o, v.e_wb);
  endtask

  initial begin
    mode_i = '0; src_i = '0; size_i = '0; shamt_i = '0; sp_base_i = 1'b0;
    base_i = '0; index_i = '0; imm_i = '0; pc_i = '0;
    rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    // idle: all-zero inputs give offset mode at address zero
    check("R1", "idle addr", addr_o, 64'h0);
    check("R11", "idle wb_en", 64'(wb_en_o), 64'h0);
    check("R9", "idle fault", 64'(align_fault_o), 64'h0);
    check("R8", "idle reject", 64'(reject_o), 64'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      check_vec(VECS[i]);
    end

    // R4: shift by the largest amount moves bit 0 to the top
    apply('{2'd0, 2'd2, 2'd0, 6'd63, 1'b0, 64'h0, 64'h1, 12'h0, 64'h0,
            64'h8000_0000_0000_0000, 64'h0, 1'b0, 1'b0, 1'b0, 8'd4});
    check("R4", "max shift addr", addr_o, 64'h8000_0000_0000_0000);

    // R10: base changes do not move the literal address
    apply('{2'd3, 2'd0, 2'd0, 6'd0, 1'b0, 64'hDEAD_0000, 64'h0, 12'h004, 64'h100,
            64'h104, 64'h0, 1'b0, 1'b0, 1'b0, 8'd10});
    check("R10", "literal base ignored", addr_o, 64'h104);

    // R2: maximum unsigned immediate at doubleword scale
    apply('{2'd0, 2'd0, 2'd3, 6'd0, 1'b0, 64'h0, 64'h0, 12'hFFF, 64'h0,
            64'h7FF8, 64'h0, 1'b0, 1'b0, 1'b0, 8'd2});
    check("R2", "max uimm", addr_o, 64'h7FF8);

    // R7: most negative short immediate in post-index
    apply('{2'd2, 2'd0, 2'd0, 6'd0, 1'b0, 64'h1000, 64'h0, 12'h100, 64'h0,
            64'h1000, 64'h0F00, 1'b1, 1'b0, 1'b0, 8'd7});
    check("R7", "min simm wb", wb_data_o, 64'h0F00);
    check("R6", "min simm addr", addr_o, 64'h1000);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule